// File: doc/BRIEF.md
# Two-Bank Interleaved DRAM Read/Write Sequencer

This block sits between a simple CPU-side word port and a pair of DRAM banks. Consecutive 16-bit words alternate between the two banks: word address bit 0 (byte address bit 1) picks the bank. Each bank has its own timing counter. After a bank's row/column access ends, the bank stays in precharge, and during that time the other bank may start its own access. A stream of sequential words therefore completes at access-time pace. Two accesses in a row to the same bank are held back until the first bank's full cycle time has passed.

The CPU presents `req_i` with a word address, write enable, write data and two byte enables. The sequencer starts the access when the target bank is free and no other access is in flight. It drives that bank's row strobe with the row address, then the column strobe with the column address a parameterised delay later. It returns a one-cycle `ready_o` pulse. In the ready cycle the CPU must withdraw or replace its request. Each byte lane has an even-parity bit, which is generated on writes and checked on reads.

Timing is set in clock cycles through `T_RCD` (row to column strobe), `T_RAC` (strobe active time) and `T_RC` (full cycle including precharge), with `T_RCD < T_RAC < T_RC`.

Top module: `ilv_dram_seq`

## Requirements
- R1: The bank is selected by word address bit 0 (0 selects bank 0, 1 selects bank 1). Only that bank's row strobe falls, and at most one row strobe is low in any cycle.
- R2: The row strobe of the selected bank stays low for exactly `T_RAC` cycles, with the row address (word address bits AW-1..COL_W+1) on `mem_addr_o`. The column strobe falls exactly `T_RCD` cycles after the row strobe and carries the column address (word address bits COL_W..1).
- R3: When successive requests go to alternate banks back to back, `ready_o` pulses every `T_RAC+1` cycles.
- R4: Two row strobe falls on the same bank are at least `T_RC` cycles apart. For back-to-back requests to the same bank, the latency is max(`T_RC`, `T_RAC+1`) cycles.
- R5: A request to an idle bank, presented while nothing is in flight, gets `ready_o` `T_RAC+1` rising edges after it is presented.
- R6: `ready_o` is a single-cycle pulse. On a read, `rdata_o` holds the word last written to that address when `ready_o` is high.
- R7: On a write, stored bit 16 is the even parity of data bits 7..0 and stored bit 17 is the even parity of data bits 15..8, so each lane plus its parity bit has an even number of ones.
- R8: Byte enable bit 0 gates lane 0 (bits 7..0 and parity bit 16) and bit 1 gates lane 1 (bits 15..8 and parity bit 17). A disabled lane keeps its old contents, and with both enables low the word is unchanged.
- R9: `parity_err_o` is high with `ready_o` on a read where either lane fails its parity check. It is low on reads with correct parity and on all writes.
- R10: After reset both banks are available, all strobes are high, `mem_we_n_o` is high and `ready_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, held until ready |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Word address |
| wdata_i | input | 16 | Write data |
| be_i | input | 2 | Byte lane enables for writes |
| rdata_o | output | 16 | Read data, valid with ready on reads |
| ready_o | output | 1 | One-cycle completion pulse |
| parity_err_o | output | 1 | Read parity mismatch, valid with ready |
| ras_n_o | output | 2 | Per-bank row strobe, active low |
| cas_n_o | output | 2 | Per-bank column strobe, active low |
| mem_addr_o | output | MA_W | Shared multiplexed row/column address |
| mem_we_n_o | output | 1 | Write enable to the banks, active low |
| mem_wbe_o | output | 2 | Per-lane write strobes |
| mem_wdata_o | output | 18 | Write word with lane parity bits 17..16 |
| mem_rdata0_i | input | 18 | Read word from bank 0 |
| mem_rdata1_i | input | 18 | Read word from bank 1 |

## Verification
The assertions watch every cycle for properties that hold cycle by cycle. No two row strobes are low together. A column strobe only falls after its row strobe has been low. `ready_o` never lasts two cycles, a parity error only appears alongside ready, and lane write strobes only appear with the write enable. Other behaviour depends on a memory behind the strobes and on whole access sequences, so only the bench's scenarios can show it. This covers the exact strobe widths and delays, the latency differences between alternating and same-bank streams, the stored parity bits, byte-lane masking and detection of corrupted words.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  localparam int LANE_W = 8;
  localparam int LANES  = 2;
  localparam int DATA_W = LANE_W * LANES;
  localparam int CODE_W = DATA_W + LANES;

  typedef logic [DATA_W-1:0] word_t;
  typedef logic [CODE_W-1:0] code_t;
  typedef logic [LANES-1:0]  lane_t;
endpackage

// File: rtl/ilv_parity.sv
module ilv_parity
  import ilv_pkg::*;
(
  input  word_t wdata_i,
  input  code_t rword_i,
  output code_t wcode_o,
  output logic  err_o
);
  lane_t gen_par;
  lane_t mism;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign gen_par[l] = ^wdata_i[l*LANE_W +: LANE_W];
    assign mism[l]    = (^rword_i[l*LANE_W +: LANE_W]) != rword_i[DATA_W + l];
  end

  assign wcode_o = {gen_par, wdata_i};
  assign err_o   = |mism;
endmodule

// File: rtl/ilv_bank_timer.sv
module ilv_bank_timer #(
  parameter int T_RCD = 2,
  parameter int T_RAC = 4,
  parameter int T_RC  = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic free_o,
  output logic busy_o,
  output logic last_o,
  output logic col_o,
  output logic ras_n_o,
  output logic cas_n_o
);
  localparam int PW = $clog2(T_RC + 1);
  localparam logic [PW-1:0] PH_RCD  = PW'(T_RCD);
  localparam logic [PW-1:0] PH_RAC  = PW'(T_RAC);
  localparam logic [PW-1:0] PH_RAC1 = PW'(T_RAC - 1);
  localparam logic [PW-1:0] PH_RC1  = PW'(T_RC - 1);

  logic          run_q;
  logic [PW-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      ph_q  <= '0;
    end else if (start_i) begin
      run_q <= 1'b1;
      ph_q  <= '0;
    end else if (run_q) begin
      if (ph_q == PH_RC1) begin
        run_q <= 1'b0;
        ph_q  <= '0;
      end else begin
        ph_q <= ph_q + 1'b1;
      end
    end
  end

  // last precharge cycle may hand over to a new start
  assign free_o  = !run_q || (ph_q == PH_RC1);
  assign busy_o  = run_q && (ph_q < PH_RAC);
  assign last_o  = run_q && (ph_q == PH_RAC1);
  assign col_o   = ph_q >= PH_RCD;
  assign ras_n_o = !busy_o;
  assign cas_n_o = !(busy_o && col_o);

  AST_CAS_AFTER_RAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cas_n_o) |-> $past(!ras_n_o)); // R2
endmodule

// File: rtl/ilv_dram_seq.sv
module ilv_dram_seq
  import ilv_pkg::*;
#(
  parameter int AW    = 8,
  parameter int COL_W = 4,
  parameter int T_RCD = 2,
  parameter int T_RAC = 4,
  parameter int T_RC  = 7,
  localparam int ROW_W = AW - 1 - COL_W,
  localparam int MA_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [15:0]       wdata_i,
  input  logic [1:0]        be_i,
  output logic [15:0]       rdata_o,
  output logic              ready_o,
  output logic              parity_err_o,
  output logic [1:0]        ras_n_o,
  output logic [1:0]        cas_n_o,
  output logic [MA_W-1:0]   mem_addr_o,
  output logic              mem_we_n_o,
  output logic [1:0]        mem_wbe_o,
  output logic [17:0]       mem_wdata_o,
  input  logic [17:0]       mem_rdata0_i,
  input  logic [17:0]       mem_rdata1_i
);
  localparam int NBANK = 2;

  logic [NBANK-1:0] free_v, busy_v, last_v, col_v, start_v;
  logic             start, fin;

  logic          acc_q, cur_q, we_q, ready_q, perr_q;
  logic [AW-1:0] addr_q;
  lane_t         be_q;
  word_t         wd_q, rdata_q;

  code_t rd_sel, wcode;
  logic  perr_w, cas_act, wr_act;

  assign start = req_i && !acc_q && free_v[addr_i[0]];
  assign fin   = acc_q && last_v[cur_q];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign start_v[b] = start && (addr_i[0] == 1'(b));
    ilv_bank_timer #(.T_RCD(T_RCD), .T_RAC(T_RAC), .T_RC(T_RC)) u_tmr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (start_v[b]),
      .free_o  (free_v[b]),
      .busy_o  (busy_v[b]),
      .last_o  (last_v[b]),
      .col_o   (col_v[b]),
      .ras_n_o (ras_n_o[b]),
      .cas_n_o (cas_n_o[b])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= 1'b0;
      cur_q   <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      be_q    <= '0;
      wd_q    <= '0;
      ready_q <= 1'b0;
      perr_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      ready_q <= fin;
      perr_q  <= fin && !we_q && perr_w;
      if (fin && !we_q) rdata_q <= rd_sel[DATA_W-1:0];
      if (start) begin
        acc_q  <= 1'b1;
        cur_q  <= addr_i[0];
        we_q   <= we_i;
        addr_q <= addr_i;
        be_q   <= be_i;
        wd_q   <= wdata_i;
      end else if (fin) begin
        acc_q <= 1'b0;
      end
    end
  end

  assign rd_sel = cur_q ? mem_rdata1_i : mem_rdata0_i;

  ilv_parity u_par (
    .wdata_i (wd_q),
    .rword_i (rd_sel),
    .wcode_o (wcode),
    .err_o   (perr_w)
  );

  logic [ROW_W-1:0] row_w;
  logic [COL_W-1:0] col_w;
  assign row_w = addr_q[AW-1:COL_W+1];
  assign col_w = addr_q[COL_W:1];

  assign mem_addr_o  = col_v[cur_q] ? MA_W'(col_w) : MA_W'(row_w);
  assign cas_act     = acc_q && !cas_n_o[cur_q];
  assign wr_act      = cas_act && we_q;
  assign mem_we_n_o  = !wr_act;
  assign mem_wbe_o   = wr_act ? be_q : 2'b00;
  assign mem_wdata_o = wcode;

  assign rdata_o      = rdata_q;
  assign ready_o      = ready_q;
  assign parity_err_o = perr_q;

  AST_ONE_RAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~ras_n_o) <= 1); // R1
  AST_READY_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o); // R6
  AST_PERR_ON_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    parity_err_o |-> ready_o); // R9
  AST_WBE_ONLY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wbe_o != 2'b00) |-> !mem_we_n_o); // R8
endmodule

// File: tb/tb_ilv_dram_seq.sv
module tb_ilv_dram_seq;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int AW = 8, COLW = 4, TRCD = 2, TRAC = 4, TRC = 7;
  localparam int LAT_ALT  = TRAC + 1;
  localparam int LAT_SAME = (TRC > TRAC + 1) ? TRC : TRAC + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [1:0] be = '0;
  logic [15:0] rdata;
  logic ready, perr;
  logic [1:0] ras_n, cas_n, wbe;
  logic [3:0] maddr;
  logic mwe_n;
  logic [17:0] mwd, rd0, rd1;

  ilv_dram_seq #(.AW(AW), .COL_W(COLW), .T_RCD(TRCD), .T_RAC(TRAC), .T_RC(TRC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .be_i(be), .rdata_o(rdata), .ready_o(ready),
    .parity_err_o(perr), .ras_n_o(ras_n), .cas_n_o(cas_n), .mem_addr_o(maddr),
    .mem_we_n_o(mwe_n), .mem_wbe_o(wbe), .mem_wdata_o(mwd),
    .mem_rdata0_i(rd0), .mem_rdata1_i(rd1)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nchk = 0, nerr = 0;
  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input int a);
    return 16'((a * 40503) ^ 23130);
  endfunction

  function automatic logic [6:0] widx(input logic [7:0] a);
    return {a[7:5], a[4:1]};
  endfunction

  // memory model behind the strobes
  logic [17:0] mem [2][128];
  logic [1:0]  ras_p, cas_p;
  int          ras_t [2];
  int          last_fall [2];
  logic [2:0]  row_l [2];
  logic [3:0]  col_l [2];
  logic        exp_bank = 1'b0;
  logic [2:0]  exp_row = '0;
  logic [3:0]  exp_col = '0;
  int          flip_cnt = 0, flip_seen = 0;
  int          flip_b = 0, flip_i = 0, flip_bit = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++) begin
        for (int i = 0; i < 128; i++) mem[b][i] = '0;
        last_fall[b] = -1000;
        ras_t[b] = 0;
        row_l[b] = '0;
        col_l[b] = '0;
      end
      ras_p = 2'b11;
      cas_p = 2'b11;
    end else begin
      if (flip_cnt != flip_seen) begin
        mem[flip_b][flip_i][flip_bit] = ~mem[flip_b][flip_i][flip_bit];
        flip_seen = flip_cnt;
      end
      for (int b = 0; b < 2; b++) begin
        if (ras_p[b] && !ras_n[b]) begin
          chk(b == int'(exp_bank), "R1 row strobe bank", b, exp_bank);
          chk(maddr == {1'b0, exp_row}, "R2 row address", maddr, exp_row);
          chk(cyc - last_fall[b] >= TRC, "R4 same-bank strobe spacing", cyc - last_fall[b], TRC);
          last_fall[b] = cyc;
          ras_t[b] = cyc;
          row_l[b] = maddr[2:0];
        end
        if (!ras_p[b] && ras_n[b])
          chk(cyc - ras_t[b] == TRAC, "R2 row strobe width", cyc - ras_t[b], TRAC);
        if (cas_p[b] && !cas_n[b]) begin
          chk(cyc - ras_t[b] == TRCD, "R2 column strobe delay", cyc - ras_t[b], TRCD);
          chk(maddr == exp_col, "R2 column address", maddr, exp_col);
          col_l[b] = maddr;
        end
        if (!cas_n[b] && !mwe_n) begin
          if (wbe[0]) begin
            mem[b][{row_l[b], col_l[b]}][7:0] = mwd[7:0];
            mem[b][{row_l[b], col_l[b]}][16]  = mwd[16];
          end
          if (wbe[1]) begin
            mem[b][{row_l[b], col_l[b]}][15:8] = mwd[15:8];
            mem[b][{row_l[b], col_l[b]}][17]   = mwd[17];
          end
        end
      end
      ras_p = ras_n;
      cas_p = cas_n;
    end
  end

  assign rd0 = mem[0][{row_l[0], col_l[0]}];
  assign rd1 = mem[1][{row_l[1], col_l[1]}];

  task automatic acc(input logic w, input logic [7:0] a, input logic [15:0] d,
                     input logic [1:0] e, output logic [15:0] r, output logic pe,
                     output int lat);
    int c0;
    exp_bank = a[0];
    exp_row  = a[7:5];
    exp_col  = a[4:1];
    req = 1'b1; we = w; addr = a; wdata = d; be = e;
    c0 = cyc;
    do @(negedge clk); while (!ready);
    r = rdata;
    pe = perr;
    lat = cyc - c0;
  endtask

  task automatic idle(input int n);
    req = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic flip(input int b, input int i, input int bit_n);
    flip_b = b; flip_i = i; flip_bit = bit_n;
    flip_cnt++;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    nerr++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [15:0] r;
    logic pe;
    int lat;
    logic [17:0] m;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10
    chk(ras_n == 2'b11, "R10 row strobes idle", ras_n, 3);
    chk(cas_n == 2'b11, "R10 column strobes idle", cas_n, 3);
    chk(mwe_n == 1'b1, "R10 write enable idle", mwe_n, 1);
    chk(ready == 1'b0, "R10 ready low", ready, 0);

    // write sweep, alternating banks
    for (int a = 0; a < 256; a++) begin
      acc(1'b1, 8'(a), pat(a), 2'b11, r, pe, lat);
      if (a == 0) chk(lat == LAT_ALT, "R5 idle latency", lat, LAT_ALT);
      else        chk(lat == LAT_ALT, "R3 alternating write pitch", lat, LAT_ALT);
      chk(pe == 1'b0, "R9 no error on write", pe, 0);
    end
    idle(TRC + 2);

    // stored parity
    for (int a = 0; a < 256; a++) begin
      m = mem[a % 2][widx(8'(a))];
      chk(m[15:0] == pat(a), "R7 stored data", m[15:0], pat(a));
      chk(m[16] == ^m[7:0] && m[17] == ^m[15:8], "R7 lane parity bits", m[17:16],
          {^m[15:8], ^m[7:0]});
    end

    // read sweep
    for (int a = 0; a < 256; a++) begin
      acc(1'b0, 8'(a), 16'h0, 2'b00, r, pe, lat);
      if (a == 0) chk(lat == LAT_ALT, "R5 idle latency", lat, LAT_ALT);
      else        chk(lat == LAT_ALT, "R3 alternating read pitch", lat, LAT_ALT);
      chk(r == pat(a), "R6 read data", r, pat(a));
      chk(pe == 1'b0, "R9 clean read", pe, 0);
    end
    idle(1);
    chk(ready == 1'b0, "R6 ready single cycle", ready, 0);
    idle(TRC + 2);

    // same-bank stream
    for (int k = 0; k < 16; k++) begin
      acc(1'b0, 8'(2 * k), 16'h0, 2'b00, r, pe, lat);
      chk(lat == ((k == 0) ? LAT_ALT : LAT_SAME), "R4 same-bank latency", lat,
          (k == 0) ? LAT_ALT : LAT_SAME);
      chk(r == pat(2 * k), "R6 same-bank read data", r, pat(2 * k));
    end
    idle(TRC + 2);

    // byte lanes
    acc(1'b1, 8'd5, 16'hFFFF, 2'b01, r, pe, lat);
    acc(1'b1, 8'd6, 16'h0000, 2'b10, r, pe, lat);
    acc(1'b1, 8'd7, 16'h1234, 2'b00, r, pe, lat);
    acc(1'b0, 8'd5, 16'h0, 2'b00, r, pe, lat);
    chk(r == {pat(5)[15:8], 8'hFF}, "R8 lane 0 only", r, {pat(5)[15:8], 8'hFF});
    chk(pe == 1'b0, "R8 partial write parity", pe, 0);
    acc(1'b0, 8'd6, 16'h0, 2'b00, r, pe, lat);
    chk(r == {8'h00, pat(6)[7:0]}, "R8 lane 1 only", r, {8'h00, pat(6)[7:0]});
    chk(pe == 1'b0, "R8 partial write parity", pe, 0);
    acc(1'b0, 8'd7, 16'h0, 2'b00, r, pe, lat);
    chk(r == pat(7), "R8 no lane enabled", r, pat(7));
    idle(TRC + 2);

    // parity errors
    flip(1, int'(widx(8'd9)), 16);
    acc(1'b0, 8'd9, 16'h0, 2'b00, r, pe, lat);
    chk(pe == 1'b1, "R9 lane 0 parity error", pe, 1);
    chk(r == pat(9), "R9 data with lane 0 error", r, pat(9));
    idle(TRC + 2);
    flip(0, int'(widx(8'd10)), 15);
    acc(1'b0, 8'd10, 16'h0, 2'b00, r, pe, lat);
    chk(pe == 1'b1, "R9 lane 1 parity error", pe, 1);
    idle(1);
    chk(perr == 1'b0, "R9 error only with ready", perr, 0);
    idle(TRC + 2);
    acc(1'b1, 8'd10, 16'hA5C3, 2'b11, r, pe, lat);
    chk(pe == 1'b0, "R9 no error on write", pe, 0);
    acc(1'b0, 8'd10, 16'h0, 2'b00, r, pe, lat);
    chk(pe == 1'b0 && r == 16'hA5C3, "R9 rewritten word clean", {pe, r}, 16'hA5C3);
    idle(TRC + 2);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule